// File: doc/BRIEF.md
# Synchronous Burst ROM Read Port

This block is the device side of a synchronous read-only memory with a multiplexed address bus. Every command and address is taken on the rising clock edge. An activate command latches a row address. A later read command latches a column address and returns a burst of data words after a programmable latency. A mode-set command reprograms the row-to-read latency, the read latency, the burst length and the burst order.

The array is a fixed constant function of the address, so no memory initialisation file is needed. A static strap selects 32-bit words or 16-bit half-words. In 16-bit mode there are twice as many addressable words, and each read returns one half of a 32-bit array word. A per-cycle mask input releases the data pins for the masked cycle, two clocks after it is sampled. A read that has no usable row is dropped and sets a sticky error flag.

Top module: `sbrom_port`

## Requirements
- R1: After reset `dq_oe` is low, `dq` is zero and `rd_err` is low. The mode is row latency 1, read latency 3, burst length 4, sequential order.
- R2: `cmd` is sampled only on the rising edge of `clk`, with the encoding 00 no-op, 01 activate (row from `addr[12:0]`), 10 read (column from `addr`), 11 mode-set.
- R3: A mode-set takes its fields from `addr`: bit 0 selects burst length 8 (else 4), bit 1 selects interleaved order (else sequential), bits 4:2 give the read latency, and bits 6:5 give the row latency. A read latency outside 3..6 or a row latency outside 1..2 leaves the whole mode unchanged.
- R4: A read sampled at edge k with read latency CL drives its first word after edge k+CL-1, so a receiver samples it at edge k+CL. One word follows on every later cycle for the burst length. `dq_oe` is low in every other cycle.
- R5: A read is used only if an activate happened at least RL edges earlier, where RL is the row latency in force at that activate. Any other read produces no data and sets `rd_err`.
- R6: `rd_err` stays high until reset once it is set.
- R7: In sequential order, word i of a burst of length BL is at column base + ((s+i) mod BL). Here s is the read column mod BL and base is the read column with its low log2(BL) bits cleared.
- R8: In interleaved order, word i is at column base + (s XOR i).
- R9: Array content at a 32-bit word address A is (A * 0x9E3779B1) XOR A, computed in 32 bits. In 32-bit mode (`x32_mode`=1) A = {row, addr[7:0] of the read}.
- R10: In 16-bit mode the column is `addr[8:0]`. The half-word address is H = {row, column}. `dq[15:0]` carries the upper half of word H>>1 when H is odd and the lower half when H is even. `dq[31:16]` is zero.
- R11: When `dqm` is sampled high at edge m, `dq_oe` is low and `dq` is zero during the cycle after edge m+1, whatever data was due then.
- R12: A read accepted while a burst is still being issued cuts that burst short. Words of the old burst that are already in flight still appear, and the new burst follows its own latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd | input | 2 | Command code |
| addr | input | 13 | Multiplexed row / column / mode address |
| dqm | input | 1 | Output mask, acts two clocks later |
| x32_mode | input | 1 | Static: 1 = 32-bit words, 0 = 16-bit words |
| dq | output | 32 | Read data, zero when not driven |
| dq_oe | output | 1 | Output enable; low means pins at high impedance |
| rd_err | output | 1 | Sticky flag for a dropped read |

## Verification
The hardest case to reach is a read that lands while an earlier burst is still in the latency pipeline, so that old and new words share the output and a mask cuts across them. The stimulus issues a second read three cycles after the first under the longest read latency. It raises the mask at a precisely counted edge inside a burst. It also issues a read one edge after an activate under row latency 2. A queued scoreboard trims the expected words of the cut burst, and every output cycle is checked against it.

// File: rtl/sbrom_pkg.sv
package sbrom_pkg;

  typedef enum logic [1:0] {
    CMD_NOP  = 2'b00,
    CMD_ACT  = 2'b01,
    CMD_READ = 2'b10,
    CMD_MRS  = 2'b11
  } cmd_e;

  typedef struct packed {
    logic [1:0] rl;
    logic [2:0] cl;
    logic       bl8;
    logic       ilv;
  } mode_t;

  // Array content as a constant function of the 32-bit word address.
  function automatic logic [31:0] rom_word(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ a;
  endfunction

endpackage

// File: rtl/sbrom_mode.sv
module sbrom_mode
  import sbrom_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mrs_en,
  input  logic [ADDR_W-1:0] addr,
  output mode_t             mode
);

  mode_t mode_q, mode_d;
  logic  legal;
  logic  ld_en;

  always_comb begin
    legal = (addr[4:2] >= 3'd3) && (addr[4:2] <= 3'd6) &&
            ((addr[6:5] == 2'd1) || (addr[6:5] == 2'd2));
    ld_en = mrs_en && legal;
    mode_d.bl8 = addr[0];
    mode_d.ilv = addr[1];
    mode_d.cl  = addr[4:2];
    mode_d.rl  = addr[6:5];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '{rl: 2'd1, cl: 3'd3, bl8: 1'b0, ilv: 1'b0};
    end else if (ld_en) begin
      mode_q <= mode_d;
    end
  end

  assign mode = mode_q;

endmodule

// File: rtl/sbrom_row.sv
module sbrom_row #(
  parameter int ROW_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_en,
  input  logic             rd_en,
  input  logic [ROW_W-1:0] row_in,
  input  logic [1:0]       rl,
  output logic [ROW_W-1:0] row,
  output logic             rd_ok,
  output logic             rd_err
);

  logic             open_q, err_q, err_d;
  logic [1:0]       cnt_q, cnt_d;
  logic [ROW_W-1:0] row_q;
  logic             cnt_en;

  always_comb begin
    rd_ok  = rd_en && open_q && (cnt_q == 2'd0);
    err_d  = err_q | (rd_en & ~rd_ok);
    cnt_en = act_en || (cnt_q != 2'd0);
    cnt_d  = act_en ? (rl - 2'd1) : (cnt_q - 2'd1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      row_q  <= '0;
    end else if (act_en) begin
      open_q <= 1'b1;
      row_q  <= row_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign row    = row_q;
  assign rd_err = err_q;

endmodule

// File: rtl/sbrom_burst.sv
module sbrom_burst #(
  parameter int ROW_W = 13,
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [ROW_W-1:0] row_in,
  input  logic [COL_W-1:0] col_in,
  input  logic             bl8,
  input  logic             ilv,
  output logic             item_v,
  output logic [ROW_W-1:0] item_row,
  output logic [COL_W-1:0] item_col
);

  localparam int PAD = COL_W - 3;

  logic             act_q, act_d, bl8_q, ilv_q, last;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] base_q, base_d;
  logic [2:0]       st_q, st_d, idx_q, idx_d, msk_q, msk_in, off;
  logic             run_en;

  always_comb begin
    msk_in = bl8 ? 3'b111 : 3'b011;
    msk_q  = bl8_q ? 3'b111 : 3'b011;
    base_d = col_in & ~{{PAD{1'b0}}, msk_in};
    st_d   = col_in[2:0] & msk_in;
    off    = (ilv_q ? (st_q ^ idx_q) : (st_q + idx_q)) & msk_q;
    last   = (idx_q == msk_q);
    act_d  = start || (act_q && !last);
    idx_d  = start ? 3'd0 : idx_q + 3'd1;
    run_en = start || act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      idx_q <= '0;
    end else if (run_en) begin
      act_q <= act_d;
      idx_q <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q  <= '0;
      base_q <= '0;
      st_q   <= '0;
      bl8_q  <= 1'b0;
      ilv_q  <= 1'b0;
    end else if (start) begin
      row_q  <= row_in;
      base_q <= base_d;
      st_q   <= st_d;
      bl8_q  <= bl8;
      ilv_q  <= ilv;
    end
  end

  assign item_v   = act_q;
  assign item_row = row_q;
  assign item_col = base_q | {{PAD{1'b0}}, off};

endmodule

// File: rtl/sbrom_out.sv
module sbrom_out
  import sbrom_pkg::*;
#(
  parameter int ROW_W  = 13,
  parameter int COL_W  = 9,
  parameter int CL_MAX = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             item_v,
  input  logic [ROW_W-1:0] item_row,
  input  logic [COL_W-1:0] item_col,
  input  logic [2:0]       cl,
  input  logic             x32_mode,
  input  logic             dqm,
  output logic [31:0]      dq,
  output logic             dq_oe
);

  localparam int DEPTH = CL_MAX - 1;
  localparam int AW    = ROW_W + COL_W - 1;

  logic             pv_q [DEPTH];
  logic [ROW_W-1:0] pr_q [DEPTH];
  logic [COL_W-1:0] pc_q [DEPTH];
  logic             pv_d [DEPTH];
  logic [ROW_W-1:0] pr_d [DEPTH];
  logic [COL_W-1:0] pc_d [DEPTH];
  logic             m1_q, m2_q;
  logic [2:0]       tap;
  logic             sel_v;
  logic [ROW_W-1:0] sel_r;
  logic [COL_W-1:0] sel_c;
  logic [31:0]      wa, w, data;

  always_comb begin
    for (int j = 0; j < DEPTH; j++) begin
      if (j == 0) begin
        pv_d[j] = item_v;
        pr_d[j] = item_row;
        pc_d[j] = item_col;
      end else begin
        pv_d[j] = pv_q[j-1];
        pr_d[j] = pr_q[j-1];
        pc_d[j] = pc_q[j-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < DEPTH; j++) begin
        pv_q[j] <= 1'b0;
        pr_q[j] <= '0;
        pc_q[j] <= '0;
      end
      m1_q <= 1'b0;
      m2_q <= 1'b0;
    end else begin
      for (int j = 0; j < DEPTH; j++) begin
        pv_q[j] <= pv_d[j];
        pr_q[j] <= pr_d[j];
        pc_q[j] <= pc_d[j];
      end
      m1_q <= dqm;
      m2_q <= m1_q;
    end
  end

  always_comb begin
    tap   = cl - 3'd2;
    sel_v = 1'b0;
    sel_r = '0;
    sel_c = '0;
    for (int j = 0; j < DEPTH; j++) begin
      if (tap == 3'(j)) begin
        sel_v = pv_q[j];
        sel_r = pr_q[j];
        sel_c = pc_q[j];
      end
    end
    wa = '0;
    if (x32_mode) wa[AW-1:0] = {sel_r, sel_c[COL_W-2:0]};
    else          wa[AW-1:0] = {sel_r, sel_c[COL_W-1:1]};
    w = rom_word(wa);
    if (x32_mode)      data = w;
    else if (sel_c[0]) data = {16'h0, w[31:16]};
    else               data = {16'h0, w[15:0]};
    dq_oe = sel_v && !m2_q;
    dq    = dq_oe ? data : '0;
  end

endmodule

// File: rtl/sbrom_port.sv
module sbrom_port
  import sbrom_pkg::*;
#(
  parameter int ROW_W  = 13,
  parameter int COL_W  = 9,
  parameter int CL_MAX = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cmd,
  input  logic [ROW_W-1:0] addr,
  input  logic             dqm,
  input  logic             x32_mode,
  output logic [31:0]      dq,
  output logic             dq_oe,
  output logic             rd_err
);

  mode_t            mode;
  logic             act_en, rd_en, mrs_en, rd_ok;
  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] col_in;
  logic             item_v;
  logic [ROW_W-1:0] item_row;
  logic [COL_W-1:0] item_col;

  always_comb begin
    act_en = (cmd == CMD_ACT);
    rd_en  = (cmd == CMD_READ);
    mrs_en = (cmd == CMD_MRS);
    col_in = x32_mode ? {1'b0, addr[COL_W-2:0]} : addr[COL_W-1:0];
  end

  sbrom_mode #(.ADDR_W(ROW_W)) i_mode (
    .clk(clk), .rst_n(rst_n), .mrs_en(mrs_en), .addr(addr), .mode(mode)
  );

  sbrom_row #(.ROW_W(ROW_W)) i_row (
    .clk(clk), .rst_n(rst_n), .act_en(act_en), .rd_en(rd_en),
    .row_in(addr), .rl(mode.rl), .row(row), .rd_ok(rd_ok), .rd_err(rd_err)
  );

  sbrom_burst #(.ROW_W(ROW_W), .COL_W(COL_W)) i_burst (
    .clk(clk), .rst_n(rst_n), .start(rd_ok), .row_in(row), .col_in(col_in),
    .bl8(mode.bl8), .ilv(mode.ilv),
    .item_v(item_v), .item_row(item_row), .item_col(item_col)
  );

  sbrom_out #(.ROW_W(ROW_W), .COL_W(COL_W), .CL_MAX(CL_MAX)) i_out (
    .clk(clk), .rst_n(rst_n), .item_v(item_v), .item_row(item_row),
    .item_col(item_col), .cl(mode.cl), .x32_mode(x32_mode), .dqm(dqm),
    .dq(dq), .dq_oe(dq_oe)
  );

endmodule

// File: rtl/sbrom_chk.sv
module sbrom_chk
  import sbrom_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  cmd,
  input logic        dqm,
  input logic        x32_mode,
  input logic [31:0] dq,
  input logic        dq_oe,
  input logic        rd_err
);

  logic [1:0] warm_q;
  logic       seen_act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warm_q     <= '0;
      seen_act_q <= 1'b0;
    end else begin
      if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
      if (cmd == CMD_ACT) seen_act_q <= 1'b1;
    end
  end

  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |=> rd_err);

  p_mask_delay_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((warm_q == 2'd2) && $past(dqm, 2)) |-> !dq_oe);

  p_released_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> (dq == 32'h0));

  p_half_upper_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && !x32_mode) |-> (dq[31:16] == 16'h0));

  p_no_row_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd == CMD_READ) && !seen_act_q) |=> rd_err);

endmodule

bind sbrom_port sbrom_chk i_chk (
  .clk(clk), .rst_n(rst_n), .cmd(cmd), .dqm(dqm), .x32_mode(x32_mode),
  .dq(dq), .dq_oe(dq_oe), .rd_err(rd_err)
);

// File: tb/test_sbrom_port.sv
module test_sbrom_port;

  typedef struct {
    int          cyc;
    logic [31:0] data;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cmd = 2'b00;
  logic [12:0] addr = '0;
  logic        dqm = 1'b0;
  logic        x32_mode = 1'b1;
  logic [31:0] dq;
  logic        dq_oe;
  logic        rd_err;

  int   cyc = 0;
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   run = 0;
  bit   done = 0;
  exp_t q[$];
  bit   masked[int];

  int          m_cl = 3, m_bl = 4, m_rl = 1;
  bit          m_ilv = 0;
  logic [12:0] m_row = '0;

  sbrom_port i_sbrom_port (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .addr(addr), .dqm(dqm),
    .x32_mode(x32_mode), .dq(dq), .dq_oe(dq_oe), .rd_err(rd_err)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] word_at(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ a;
  endfunction

  function automatic logic [31:0] model(input logic [12:0] r, input logic [8:0] c);
    logic [31:0] w;
    logic [31:0] h;
    if (x32_mode) return word_at({11'h0, r, c[7:0]});
    h = {10'h0, r, c};
    w = word_at(h >> 1);
    return h[0] ? {16'h0, w[31:16]} : {16'h0, w[15:0]};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] c, input logic [12:0] a, input logic m);
    @(negedge clk);
    cmd  = c;
    addr = a;
    dqm  = m;
    if (m) masked[cyc + 2] = 1'b1;
  endtask

  task automatic nops(input int n);
    for (int i = 0; i < n; i++) step(2'b00, '0, 1'b0);
  endtask

  task automatic mrs(input logic [12:0] a);
    int cl_f, rl_f;
    step(2'b11, a, 1'b0);
    cl_f = int'(a[4:2]);
    rl_f = int'(a[6:5]);
    if (cl_f >= 3 && cl_f <= 6 && (rl_f == 1 || rl_f == 2)) begin
      m_cl = cl_f; m_rl = rl_f; m_bl = a[0] ? 8 : 4; m_ilv = a[1];
    end
  endtask

  task automatic act(input logic [12:0] r);
    step(2'b01, r, 1'b0);
    m_row = r;
  endtask

  // Driver: issue a read and push the expected burst onto the scoreboard.
  task automatic rd(input logic [8:0] c, input string tag);
    int k, first, st, off;
    logic [8:0] col, base;
    step(2'b10, {4'h0, c}, 1'b0);
    k     = cyc + 1;
    first = k + m_cl - 1;
    col   = x32_mode ? {1'b0, c[7:0]} : c;
    while (q.size() > 0 && q[$].cyc >= first) void'(q.pop_back());
    st   = int'(col) % m_bl;
    base = col - 9'(st);
    for (int i = 0; i < m_bl; i++) begin
      exp_t e;
      off    = m_ilv ? (st ^ i) : ((st + i) % m_bl);
      e.cyc  = first + i;
      e.data = model(m_row, base + 9'(off));
      e.tag  = tag;
      q.push_back(e);
    end
  endtask

  task automatic rd_bad(input logic [8:0] c);
    step(2'b10, {4'h0, c}, 1'b0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    run   = 0;
    rst_n = 1'b0;
    cmd   = 2'b00;
    dqm   = 1'b0;
    repeat (2) @(negedge clk);
    q.delete();
    masked.delete();
    m_cl = 3; m_bl = 4; m_rl = 1; m_ilv = 0;
    rst_n = 1'b1;
    check(dq_oe == 1'b0 && dq == '0 && rd_err == 1'b0, "R1",
          {31'h0, dq_oe, dq}, 64'h0);
    run = 1;
  endtask

  // Monitor: compare every output cycle against the scoreboard.
  always @(negedge clk) begin
    if (run) begin
      logic        e_oe;
      logic [31:0] e_d;
      string       tag;
      e_oe = 1'b0;
      e_d  = '0;
      tag  = "R4";
      if (q.size() > 0 && q[0].cyc == cyc) begin
        exp_t e;
        e    = q.pop_front();
        e_oe = 1'b1;
        e_d  = e.data;
        tag  = e.tag;
      end
      if (masked.exists(cyc)) begin
        e_oe = 1'b0;
        e_d  = '0;
        tag  = "R11";
      end
      check(dq_oe == e_oe && dq == e_d, tag, {31'h0, dq_oe, dq}, {31'h0, e_oe, e_d});
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 R2 R7 R9: default mode, 32-bit, sequential burst of 4, CL 3
    act(13'h0123);
    rd(9'h005, "R7");
    nops(12);
    check(rd_err == 1'b0, "R5", {63'h0, rd_err}, 64'h0);
    // R3 R8: BL8, interleaved, CL5, RL2
    mrs(13'h0057);
    act(13'h1ABC);
    nops(1);
    rd(9'h0F3, "R8");
    nops(14);
    // R3: reserved codes leave mode unchanged
    mrs(13'h003C);
    mrs(13'h0070);
    rd(9'h011, "R3");
    nops(14);
    // R11: sequential BL8 CL6, mask the third word
    mrs(13'h0059);
    rd(9'h02E, "R7");
    nops(5);
    step(2'b00, '0, 1'b1);
    nops(12);
    // R12: second read cuts the first burst
    rd(9'h010, "R12");
    nops(2);
    rd(9'h040, "R12");
    nops(16);
    // R10: 16-bit organisation
    @(negedge clk);
    x32_mode = 1'b0;
    mrs(13'h0030);
    act(13'h00AA);
    rd(9'h1FD, "R10");
    nops(10);
    rd(9'h102, "R10");
    nops(10);
    @(negedge clk);
    x32_mode = 1'b1;
    // R5: read one edge after activate under RL2 is dropped
    mrs(13'h004C);
    act(13'h0777);
    rd_bad(9'h008);
    nops(1);
    check(rd_err == 1'b1, "R5", {63'h0, rd_err}, 64'h1);
    rd(9'h008, "R6");
    nops(8);
    check(rd_err == 1'b1, "R6", {63'h0, rd_err}, 64'h1);
    // R5: read with no row since reset
    do_reset();
    rd_bad(9'h000);
    nops(1);
    check(rd_err == 1'b1, "R5", {63'h0, rd_err}, 64'h1);
    nops(6);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule